// File: doc/BRIEF.md
# Dual Down-Counting Interval Timers

This block holds two programmable interval timers behind a byte-wide write port. Timer A has a 10-bit count and Timer B an 8-bit count. An external base tick enable drives both through a shared prescaler. Timer A steps on every second base tick and Timer B on every sixteenth.

Each running timer counts down. When it reaches zero it reloads from its load register and keeps counting. On that expiry it can set a status flag, and the flag raises a shared interrupt. Software controls everything through one control register. That register starts a stopped timer, forces a timer to zero, enables or disables each flag, and clears each flag. The same register also holds two mode bits that are only exposed as outputs. A status byte reports both flags and an externally supplied busy bit.

Top module: `dual_interval_timer`

## Requirements
- R1: After a synchronous reset, both counters are zero, both flags are clear, `irq` is 0, both mode outputs are 0, and `status` is 0 while `busy_in` is 0.
- R2: The 10-bit Timer A reload value is built from two bytes. Address 0x24 supplies value bits 9..2 and bits 1..0 of address 0x25 supply value bits 1..0. The 8-bit Timer B reload value is written at address 0x26.
- R3: The control register is at address 0x27. Its bits are: bit7 composite-sine mode, bit6 three-slot mode, bit5 clear B flag, bit4 clear A flag, bit3 B flag enable, bit2 A flag enable, bit1 start B, bit0 start A. Bits 7 and 6 appear on `composite_mode` and `slot3_mode` from the edge that takes the write.
- R4: A control write with a timer's start bit at 0 forces that timer's counter to zero. A counter at zero never steps and never expires.
- R5: A control write with a timer's start bit at 1 copies that timer's reload value into the counter only when the counter is zero. A running counter keeps counting as if the write had not happened.
- R6: When a step finds the counter at 1, the timer expires and the counter reloads from the reload register in the same edge. With tick enable held high, Timer A therefore expires every 2·N clock cycles for a reload value N.
- R7: A timer's flag is set on expiry only when that timer's enable bit is 1. A control write with the matching clear bit at 1 clears the flag. If expiry and clear happen in the same cycle, the set wins.
- R8: The `status` byte carries the A flag in bit0, the B flag in bit1, and `busy_in` delayed by one clock in bit7. Bits 6..2 read 0.
- R9: Timer A steps on every 2nd base tick and Timer B on every 16th base tick. Cycles without `base_tick` do not count.
- R10: `irq` is 1 whenever either flag is set and stays 1 until both flags are cleared.
- R11: Writing a reload register does not change a running counter. The new value takes effect at the next expiry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_tick | input | 1 | Base tick enable feeding the prescaler |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 8 | Register address |
| wr_data | input | 8 | Register write data |
| busy_in | input | 1 | Busy indication copied into status bit7 |
| status | output | 8 | Status byte: A flag, B flag, busy |
| irq | output | 1 | Shared interrupt, OR of the two flags |
| composite_mode | output | 1 | Stored composite-sine mode bit |
| slot3_mode | output | 1 | Stored three-slot mode bit |

## Verification
A write sampled at a rising edge takes effect at that same edge. Counter loads, forced zeroes, mode bits and flag clears are therefore visible at the next falling edge. An expiry sets its flag, and so `irq`, at the edge where the step finds the counter at 1, while `busy_in` reaches status bit7 one edge after it is sampled. The bench drives inputs and compares every output on falling edges against a behavioural model that advances on rising edges. The directed checks measure expiry intervals as the number of cycles between two flag rises, so the prescaler phase at start-up does not enter the expected values.

// File: rtl/dit_pkg.sv
package dit_pkg;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 8;
  localparam int NUM_TMR = 2;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] data_t;

  // register addresses (decoded by software drivers, so positions are fixed)
  localparam addr_t ADR_A_HI = 8'h24;
  localparam addr_t ADR_A_LO = 8'h25;
  localparam addr_t ADR_B    = 8'h26;
  localparam addr_t ADR_CTRL = 8'h27;

  // control register bit positions
  localparam int CB_START_A  = 0;
  localparam int CB_START_B  = 1;
  localparam int CB_EN_A     = 2;
  localparam int CB_EN_B     = 3;
  localparam int CB_CLR_A    = 4;
  localparam int CB_CLR_B    = 5;
  localparam int CB_SLOT3    = 6;
  localparam int CB_COMPOSITE = 7;
endpackage

// File: rtl/tick_divider.sv
module tick_divider #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  output logic step
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] phase;
  logic          wrap;

  assign wrap = (phase == CW'(DIV - 1));
  assign step = tick && wrap;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
    end else if (tick) begin
      phase <= wrap ? '0 : phase + CW'(1);
    end
  end
endmodule

// File: rtl/down_counter.sv
module down_counter #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic         ctl_wr,
  input  logic         ctl_start,
  input  logic [W-1:0] reload,
  output logic [W-1:0] cnt,
  output logic         expire
);
  logic at_zero;
  logic force_zero;

  assign at_zero    = (cnt == '0);
  assign force_zero = ctl_wr && !ctl_start;
  assign expire     = step && (cnt == W'(1)) && !force_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (force_zero) begin
      cnt <= '0;
    end else if (ctl_wr && at_zero) begin
      cnt <= reload;
    end else if (step && !at_zero) begin
      cnt <= (cnt == W'(1)) ? reload : cnt - W'(1);
    end
  end
endmodule

// File: rtl/timer_regs.sv
module timer_regs
  import dit_pkg::*;
#(
  parameter int TA_W = 10,
  parameter int TB_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  addr_t           wr_addr,
  input  data_t           wr_data,
  output logic [TA_W-1:0] load_a,
  output logic [TB_W-1:0] load_b,
  output logic            en_a,
  output logic            en_b,
  output logic            composite_q,
  output logic            slot3_q,
  output logic            ctrl_wr
);
  localparam int LO_W = TA_W - DATA_W;

  logic [DATA_W-1:0] a_hi_q;
  logic [LO_W-1:0]   a_lo_q;
  logic [TB_W-1:0]   b_q;

  assign load_a  = {a_hi_q, a_lo_q};
  assign load_b  = b_q;
  assign ctrl_wr = wr_en && (wr_addr == ADR_CTRL);

  always_ff @(posedge clk) begin
    if (rst) begin
      a_hi_q      <= '0;
      a_lo_q      <= '0;
      b_q         <= '0;
      en_a        <= 1'b0;
      en_b        <= 1'b0;
      composite_q <= 1'b0;
      slot3_q     <= 1'b0;
    end else if (wr_en) begin
      unique case (wr_addr)
        ADR_A_HI: a_hi_q <= wr_data;
        ADR_A_LO: a_lo_q <= wr_data[LO_W-1:0];
        ADR_B:    b_q    <= wr_data[TB_W-1:0];
        ADR_CTRL: begin
          en_a        <= wr_data[CB_EN_A];
          en_b        <= wr_data[CB_EN_B];
          composite_q <= wr_data[CB_COMPOSITE];
          slot3_q     <= wr_data[CB_SLOT3];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
  import dit_pkg::*;
#(
  parameter int TA_W   = 10,
  parameter int TB_W   = 8,
  parameter int TA_DIV = 2,
  parameter int TB_DIV = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              base_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy_in,
  output logic [DATA_W-1:0] status,
  output logic              irq,
  output logic              composite_mode,
  output logic              slot3_mode
);
  localparam int PAD_W = DATA_W - NUM_TMR - 1;

  logic [TA_W-1:0]    load_a, cnt_a;
  logic [TB_W-1:0]    load_b, cnt_b;
  logic               en_a, en_b, ctrl_wr;
  logic               step_a, step_b, exp_a, exp_b;
  logic               busy_q;
  logic [NUM_TMR-1:0] flag, exp_v, en_v, clr_v;

  timer_regs #(.TA_W(TA_W), .TB_W(TB_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .load_a(load_a), .load_b(load_b), .en_a(en_a), .en_b(en_b),
    .composite_q(composite_mode), .slot3_q(slot3_mode), .ctrl_wr(ctrl_wr)
  );

  tick_divider #(.DIV(TA_DIV)) u_div_a (
    .clk(clk), .rst(rst), .tick(base_tick), .step(step_a)
  );

  tick_divider #(.DIV(TB_DIV)) u_div_b (
    .clk(clk), .rst(rst), .tick(base_tick), .step(step_b)
  );

  down_counter #(.W(TA_W)) u_cnt_a (
    .clk(clk), .rst(rst), .step(step_a), .ctl_wr(ctrl_wr),
    .ctl_start(wr_data[CB_START_A]), .reload(load_a), .cnt(cnt_a), .expire(exp_a)
  );

  down_counter #(.W(TB_W)) u_cnt_b (
    .clk(clk), .rst(rst), .step(step_b), .ctl_wr(ctrl_wr),
    .ctl_start(wr_data[CB_START_B]), .reload(load_b), .cnt(cnt_b), .expire(exp_b)
  );

  assign exp_v = {exp_b, exp_a};
  assign en_v  = {en_b, en_a};
  assign clr_v = {ctrl_wr && wr_data[CB_CLR_B], ctrl_wr && wr_data[CB_CLR_A]};

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) begin
        flag[i] <= 1'b0;
      end else if (exp_v[i] && en_v[i]) begin
        flag[i] <= 1'b1;
      end else if (clr_v[i]) begin
        flag[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
    end else begin
      busy_q <= busy_in;
    end
  end

  assign status = {busy_q, {PAD_W{1'b0}}, flag};
  assign irq    = |flag;
endmodule

// File: rtl/dual_interval_timer_checker.sv
module dual_interval_timer_checker #(
  parameter int TA_W = 10
) (
  input logic            clk,
  input logic            rst,
  input logic            ctl_wr,
  input logic            ctl_start_a,
  input logic            ctl_clr_a,
  input logic            ctl_clr_b,
  input logic [TA_W-1:0] cnt_a,
  input logic [TA_W-1:0] load_a,
  input logic            step_a,
  input logic            step_b,
  input logic            exp_a,
  input logic            en_a,
  input logic [1:0]      flags,
  input logic            irq
);
  AST_FORCE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && !ctl_start_a) |=> (cnt_a == '0)); // R4

  AST_RUNNING_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && ctl_start_a && (cnt_a != '0) && !step_a) |=> (cnt_a == $past(cnt_a))); // R5

  AST_EXPIRE_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (exp_a && !ctl_wr) |=> (cnt_a == $past(load_a))); // R6

  AST_FLAG_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    $rose(flags[0]) |-> $past(en_a && exp_a)); // R7

  AST_FLAG_CLEARED: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && ctl_clr_a && !exp_a) |=> !flags[0]); // R7

  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (irq && !(ctl_wr && (ctl_clr_a || ctl_clr_b))) |=> irq); // R10

  AST_B_ON_A_STEP: assert property (@(posedge clk) disable iff (rst)
    step_b |-> step_a); // R9
endmodule

bind dual_interval_timer dual_interval_timer_checker #(.TA_W(TA_W)) u_checker (
  .clk(clk), .rst(rst), .ctl_wr(ctrl_wr),
  .ctl_start_a(wr_data[0]), .ctl_clr_a(wr_data[4]), .ctl_clr_b(wr_data[5]),
  .cnt_a(cnt_a), .load_a(load_a), .step_a(step_a), .step_b(step_b),
  .exp_a(exp_a), .en_a(en_a), .flags(flag), .irq(irq)
);

// File: tb/dual_interval_timer_bench.sv
module dual_interval_timer_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       base_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = 8'h00;
  logic [7:0] wr_data = 8'h00;
  logic       busy_in = 1'b0;
  logic [7:0] status;
  logic       irq, composite_mode, slot3_mode;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int tick_mode = 0;
  bit model_ok = 0;
  bit done = 0;

  // model state
  int m_ca, m_cb, m_pa, m_pb, m_ahi, m_alo, m_lb;
  bit m_ena, m_enb, m_comp, m_slot, m_fa, m_fb, m_busy;

  dual_interval_timer u_dual_interval_timer (
    .clk(clk), .rst(rst), .base_tick(base_tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy_in(busy_in), .status(status), .irq(irq),
    .composite_mode(composite_mode), .slot3_mode(slot3_mode)
  );

  always #4 clk = ~clk;

  always @(posedge clk) cyc++;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // behavioural reference model
  always @(posedge clk) begin
    if (rst) begin
      m_ca = 0; m_cb = 0; m_pa = 0; m_pb = 0; m_ahi = 0; m_alo = 0; m_lb = 0;
      m_ena = 0; m_enb = 0; m_comp = 0; m_slot = 0; m_fa = 0; m_fb = 0; m_busy = 0;
      model_ok = 1;
    end else begin
      bit sa, sb, cw, ea, eb;
      int la;
      sa = base_tick && (m_pa == 1);
      sb = base_tick && (m_pb == 15);
      if (base_tick) begin
        m_pa = (m_pa + 1) % 2;
        m_pb = (m_pb + 1) % 16;
      end
      cw = wr_en && (wr_addr == 8'h27);
      la = m_ahi * 4 + m_alo;
      ea = 0; eb = 0;
      if (cw && !wr_data[0]) m_ca = 0;
      else if (cw && m_ca == 0) m_ca = la;
      else if (sa && m_ca != 0) begin
        if (m_ca == 1) begin m_ca = la; ea = 1; end
        else m_ca = m_ca - 1;
      end
      if (cw && !wr_data[1]) m_cb = 0;
      else if (cw && m_cb == 0) m_cb = m_lb;
      else if (sb && m_cb != 0) begin
        if (m_cb == 1) begin m_cb = m_lb; eb = 1; end
        else m_cb = m_cb - 1;
      end
      if (ea && m_ena) m_fa = 1; else if (cw && wr_data[4]) m_fa = 0;
      if (eb && m_enb) m_fb = 1; else if (cw && wr_data[5]) m_fb = 0;
      if (wr_en) begin
        case (wr_addr)
          8'h24: m_ahi = wr_data;
          8'h25: m_alo = wr_data[1:0];
          8'h26: m_lb = wr_data;
          8'h27: begin
            m_ena = wr_data[2]; m_enb = wr_data[3];
            m_comp = wr_data[7]; m_slot = wr_data[6];
          end
          default: ;
        endcase
      end
      m_busy = busy_in;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (model_ok && !done) begin
      chk("R7 model A flag", status[0], m_fa);
      chk("R7 model B flag", status[1], m_fb);
      chk("R8 model busy", status[7], m_busy);
      chk("R8 model zero bits", status[6:2], 0);
      chk("R10 model irq", irq, m_fa | m_fb);
      chk("R3 model modes", {composite_mode, slot3_mode}, {m_comp, m_slot});
    end
  end

  // base tick pattern
  initial begin
    forever begin
      @(negedge clk);
      case (tick_mode)
        0: base_tick = 1'b1;
        1: base_tick = ~base_tick;
        default: base_tick = ($urandom % 3) == 0;
      endcase
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    done = 1;
    summary();
  end

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_bit(int b, output int t);
    do @(negedge clk); while (status[b] !== 1'b1);
    t = cyc;
  endtask

  initial begin
    int t1, t2, t3, t4;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset status", status, 8'h00);
    chk("R1 reset irq", irq, 0);
    chk("R1 reset modes", {composite_mode, slot3_mode}, 0);

    // R3 mode bits
    wr(8'h27, 8'hC0);
    chk("R3 composite bit7", composite_mode, 1);
    chk("R3 slot3 bit6", slot3_mode, 1);
    wr(8'h27, 8'h00);
    chk("R3 modes cleared", {composite_mode, slot3_mode}, 0);

    // R2 R6 R9: reload 5 built from two bytes, tick every cycle
    wr(8'h24, 8'h01);
    wr(8'h25, 8'h01);
    wr(8'h27, 8'h05);
    wait_bit(0, t1);
    chk("R8 status A only", status, 8'h01);
    chk("R10 irq on A flag", irq, 1);
    wr(8'h27, 8'h17);
    chk("R7 clear A flag", status[0], 0);
    wait_bit(0, t2);
    chk("R2 R6 A period 2*5", t2 - t1, 10);

    // R5 R11: new reload while running; restart ignored
    wr(8'h27, 8'h15);
    wr(8'h24, 8'h19);
    wr(8'h25, 8'h00);
    wait_bit(0, t3);
    chk("R5 R11 running period unchanged", t3 - t2, 10);
    wr(8'h27, 8'h15);
    wait_bit(0, t4);
    chk("R11 new reload 100 used", t4 - t3, 200);

    // R7 enable off: no flag
    wr(8'h27, 8'h11);
    repeat (450) @(negedge clk);
    chk("R7 disabled no flag", status[0], 0);
    chk("R10 no irq", irq, 0);

    // R4 forced zero: no expiry even when enabled
    wr(8'h27, 8'h04);
    repeat (450) @(negedge clk);
    chk("R4 stopped counter no flag", status[0], 0);

    // R9 R8 Timer B: reload 3 -> 48 cycles
    wr(8'h27, 8'h10);
    wr(8'h26, 8'h03);
    wr(8'h27, 8'h0A);
    wait_bit(1, t1);
    chk("R8 status B only", status, 8'h02);
    chk("R10 irq on B flag", irq, 1);
    wr(8'h27, 8'h2A);
    wait_bit(1, t2);
    chk("R9 B period 16*3", t2 - t1, 48);

    wr(8'h27, 8'h30);
    chk("R10 irq low after clears", irq, 0);
    chk("R7 both flags clear", status, 8'h00);

    // R9 tick every other cycle: A reload 5 -> 20 cycles
    tick_mode = 1;
    wr(8'h24, 8'h01);
    wr(8'h25, 8'h01);
    wr(8'h27, 8'h05);
    wait_bit(0, t1);
    wr(8'h27, 8'h15);
    wait_bit(0, t2);
    chk("R9 gated tick A period", t2 - t1, 20);

    // random ticks, both timers, periodic clears (model comparison)
    tick_mode = 2;
    wr(8'h24, 8'h00);
    wr(8'h25, 8'h03);
    wr(8'h26, 8'h02);
    wr(8'h27, 8'h30);
    wr(8'h27, 8'h0F);
    for (int k = 0; k < 20; k++) begin
      repeat (100) @(negedge clk);
      wr(8'h27, (k % 2 == 0) ? 8'h3F : 8'h1B);
    end

    // R8 busy one cycle late
    @(negedge clk);
    busy_in = 1'b1;
    @(negedge clk);
    chk("R8 busy in bit7", status[7], 1);
    busy_in = 1'b0;
    @(negedge clk);
    chk("R8 busy released", status[7], 0);

    done = 1;
    summary();
  end
endmodule